// File: doc/BRIEF.md
# I2C Register-File Slave

This block is a target on a two-wire serial bus that gives a host controller access to a small bank of byte-wide registers used to set up an audio processing path. The lower addresses hold control bytes that the block stores and presents on a parallel output. The next few addresses mirror read-only status bytes taken from an input vector. Any higher address reads as zero and discards writes.

The bus lines are sampled on the system clock through synchronizers. The block drives SDA only as an open-drain pull-down enable. A strap input picks one of two 7-bit device addresses. An 8-bit register pointer survives from one transaction to the next. The host can load it and write a run of bytes, or load it and then switch to reading through a repeated START. It can also read straight on from wherever the previous access left the pointer. Every data byte moves the pointer up by one, with wrap-around.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset every control byte is 0x00 and the SDA pull-down enable is inactive.
- R2: With `addr_sel` low the block answers only device address 0x1C, and with it high only 0x1D. Any other address gets no acknowledge, and the bytes that follow it in that transaction change no register.
- R3: A write transaction carries the device address with R/W = 0, then one pointer byte, then data bytes. Every one of these bytes is acknowledged. The data bytes land at the pointer, the pointer plus one, and so on. Control byte k appears on `ctrl_out[8k+7:8k]`.
- R4: A read that starts with the device address and R/W = 1, with no pointer byte, returns the register at the pointer left by the previous transaction.
- R5: A pointer byte followed by a repeated START and a read header returns data starting at that pointer, from consecutive addresses.
- R6: During a read, an acknowledge from the host makes the next byte follow. A not-acknowledge ends the read. SDA is then released and stays released through further SCL clocks until a START.
- R7: Status byte k sits at address 8+k and reads as `stat_in[8k+7:8k]`. Addresses 10 and up read 0x00. Writes to status or unused addresses are acknowledged but change no register.
- R8: The pointer is 8 bits wide. It steps from 0xFF to 0x00, so a write run that starts at 0xFF puts its second byte into control byte 0.
- R9: A STOP (SDA rising while SCL is high) in the middle of a byte abandons the transfer. The partial byte is not written, and SCL clocks after it are ignored until the next START.
- R10: The SDA pull-down enable changes only after an SCL falling edge, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_sel | input | 1 | Strap that selects 0x1D (1) or 0x1C (0) |
| stat_in | input | 16 | Two read-only status bytes |
| ctrl_out | output | 64 | Eight stored control bytes |

## Verification
A pointer that is off by one shows up at once as the wrong byte on the first read after a write. The same fault would make data written in later transactions land beside its intended slot, visible on `ctrl_out` one system cycle after the acknowledge clock begins. A protocol state that fails to leave the read phase after a host not-acknowledge would keep pulling SDA low on the next SCL clocks, so the bench watches the line across idle clocks after each read and after an aborted write. A pull-down enable that moves during SCL high would look like a false START or STOP to the host, so its timing against SCL is watched throughout the run.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_MACK
    } rf_state_e;

    typedef struct packed {
        rf_state_e            st;
        logic [BYTE_W-1:0]    shreg;
        logic [3:0]           cnt;
        logic [BYTE_W-1:0]    ptr;
        logic                 oe;
        logic                 rnw;
        logic                 mack;
    } rf_ctx_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.scl_pipe[0] = scl_i;
        sync_d.sda_pipe[0] = sda_i;
        sync_d.scl_prev    = sync_q.scl_pipe[STAGES-1];
        sync_d.sda_prev    = sync_q.sda_pipe[STAGES-1];
        for (int i = 1; i < STAGES; i++) begin
            sync_d.scl_pipe[i] = sync_q.scl_pipe[i-1];
            sync_d.sda_pipe[i] = sync_q.sda_pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_s     = sync_q.scl_pipe[STAGES-1];
    assign sda_s     = sync_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_s & sync_q.scl_prev;
    assign start_det = scl_s & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_rf_bank.sv
module i2c_rf_bank
    import i2c_rf_pkg::*;
#(
    parameter int CTRL_REGS = 8,
    parameter int STAT_REGS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [BYTE_W-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic [BYTE_W-1:0]             rd_addr,
    output logic [BYTE_W-1:0]             rd_data,
    input  logic [STAT_REGS*BYTE_W-1:0]   stat_in,
    output logic [CTRL_REGS*BYTE_W-1:0]   ctrl_out
);

    localparam int TOTAL_REGS = CTRL_REGS + STAT_REGS;

    logic [CTRL_REGS-1:0][BYTE_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < CTRL_REGS; i++) begin
            if (wr_en && wr_addr == BYTE_W'(i)) begin
                regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < TOTAL_REGS; i++) begin
            if (rd_addr == BYTE_W'(i)) begin
                if (i < CTRL_REGS) begin
                    rd_data = regs_q[i];
                end else begin
                    rd_data = stat_in[(i-CTRL_REGS)*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < CTRL_REGS; g++) begin : g_out
            assign ctrl_out[g*BYTE_W +: BYTE_W] = regs_q[g];
        end
    endgenerate

    // R7: a write outside the control range leaves every stored byte alone
    a_r7_no_write_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= BYTE_W'(CTRL_REGS)) |=> $stable(regs_q));

    // R3: stored bytes move only as a result of a write strobe
    a_r3_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q != $past(regs_q)) |-> $past(wr_en));

endmodule

// File: rtl/i2c_rf_fsm.sv
module i2c_rf_fsm
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR_0 = 7'h1C,
    parameter logic [6:0] DEV_ADDR_1 = 7'h1D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);

    localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

    rf_ctx_t    ctx_d, ctx_q;
    logic [6:0] dev_addr;
    logic       ptr_load;

    assign dev_addr = addr_sel ? DEV_ADDR_1 : DEV_ADDR_0;
    assign rd_addr  = ctx_q.ptr;
    assign wr_addr  = ctx_q.ptr;
    assign wr_data  = ctx_q.shreg;
    assign sda_oe   = ctx_q.oe;

    always_comb begin
        ctx_d    = ctx_q;
        wr_en    = 1'b0;
        ptr_load = 1'b0;
        if (stop_det) begin
            ctx_d.st = ST_IDLE;
            ctx_d.oe = 1'b0;
        end else if (start_det) begin
            ctx_d.st  = ST_DEV;
            ctx_d.cnt = '0;
            ctx_d.oe  = 1'b0;
        end else begin
            unique case (ctx_q.st)
                ST_IDLE: begin
                end
                ST_DEV: begin
                    if (scl_rise) begin
                        ctx_d.shreg = {ctx_q.shreg[BYTE_W-2:0], sda_s};
                        ctx_d.cnt   = ctx_q.cnt + 4'd1;
                    end else if (scl_fall && ctx_q.cnt == BITS_PER_BYTE) begin
                        if (ctx_q.shreg[BYTE_W-1:1] == dev_addr) begin
                            ctx_d.oe  = 1'b1;
                            ctx_d.rnw = ctx_q.shreg[0];
                            ctx_d.st  = ST_DEV_ACK;
                        end else begin
                            ctx_d.st = ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        ctx_d.cnt = '0;
                        if (ctx_q.rnw) begin
                            ctx_d.shreg = rd_data;
                            ctx_d.oe    = ~rd_data[BYTE_W-1];
                            ctx_d.st    = ST_RD;
                        end else begin
                            ctx_d.oe = 1'b0;
                            ctx_d.st = ST_REG;
                        end
                    end
                end
                ST_REG: begin
                    if (scl_rise) begin
                        ctx_d.shreg = {ctx_q.shreg[BYTE_W-2:0], sda_s};
                        ctx_d.cnt   = ctx_q.cnt + 4'd1;
                    end else if (scl_fall && ctx_q.cnt == BITS_PER_BYTE) begin
                        ptr_load  = 1'b1;
                        ctx_d.ptr = ctx_q.shreg;
                        ctx_d.oe  = 1'b1;
                        ctx_d.st  = ST_REG_ACK;
                    end
                end
                ST_REG_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        ctx_d.oe  = 1'b0;
                        ctx_d.cnt = '0;
                        ctx_d.st  = ST_WR;
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        ctx_d.shreg = {ctx_q.shreg[BYTE_W-2:0], sda_s};
                        ctx_d.cnt   = ctx_q.cnt + 4'd1;
                    end else if (scl_fall && ctx_q.cnt == BITS_PER_BYTE) begin
                        wr_en     = 1'b1;
                        ctx_d.ptr = ctx_q.ptr + 8'd1;
                        ctx_d.oe  = 1'b1;
                        ctx_d.st  = ST_WR_ACK;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (ctx_q.cnt == BITS_PER_BYTE - 4'd1) begin
                            ctx_d.oe = 1'b0;
                            ctx_d.st = ST_MACK;
                        end else begin
                            ctx_d.shreg = {ctx_q.shreg[BYTE_W-2:0], 1'b0};
                            ctx_d.oe    = ~ctx_q.shreg[BYTE_W-2];
                            ctx_d.cnt   = ctx_q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        ctx_d.mack = ~sda_s;
                        ctx_d.ptr  = ctx_q.ptr + 8'd1;
                    end else if (scl_fall) begin
                        if (ctx_q.mack) begin
                            ctx_d.shreg = rd_data;
                            ctx_d.oe    = ~rd_data[BYTE_W-1];
                            ctx_d.cnt   = '0;
                            ctx_d.st    = ST_RD;
                        end else begin
                            ctx_d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    ctx_d.st = ST_IDLE;
                    ctx_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, shreg: '0, cnt: '0, ptr: '0, oe: 1'b0, rnw: 1'b0, mack: 1'b0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // R10: the pull-down enable moves only right after SCL falls or a bus condition
    a_r10_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.oe != $past(ctx_q.oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R6: the idle state never holds SDA low
    a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_IDLE) |-> !ctx_q.oe);

    // R8: apart from a pointer load, the pointer only steps up by one modulo 256
    a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.ptr != $past(ctx_q.ptr)) |-> ($past(ptr_load) || ctx_q.ptr == $past(ctx_q.ptr) + 8'd1));

    // R2: the address acknowledge phase is entered only for the strapped address
    a_r2_ack_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_DEV_ACK && $past(ctx_q.st) == ST_DEV) |-> ($past(ctx_q.shreg[BYTE_W-1:1]) == $past(dev_addr)));

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter int         CTRL_REGS   = 8,
    parameter int         STAT_REGS   = 2,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR_0  = 7'h1C,
    parameter logic [6:0] DEV_ADDR_1  = 7'h1D
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    output logic                          sda_oe,
    input  logic                          addr_sel,
    input  logic [STAT_REGS*BYTE_W-1:0]   stat_in,
    output logic [CTRL_REGS*BYTE_W-1:0]   ctrl_out
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rf_fsm #(
        .DEV_ADDR_0 (DEV_ADDR_0),
        .DEV_ADDR_1 (DEV_ADDR_1)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel  (addr_sel),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    i2c_rf_bank #(
        .CTRL_REGS (CTRL_REGS),
        .STAT_REGS (STAT_REGS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .stat_in  (stat_in),
        .ctrl_out (ctrl_out)
    );

    // R9: bus conditions are recognised only with SCL high
    a_r9_cond_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> scl_s);

endmodule

// File: tb/i2c_regfile_slave_bench.sv
module i2c_regfile_slave_bench;

    localparam int QCLK = 10;
    localparam logic [6:0] ADR0 = 7'h1C;
    localparam logic [6:0] ADR1 = 7'h1D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b0;
    logic [15:0] stat_in = 16'h5AC3;
    logic [63:0] ctrl_out;
    logic        sda_oe;
    logic        sda_line;

    int checks = 0;
    int errors = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_regfile_slave u_i2c_regfile_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .addr_sel (addr_sel),
        .stat_in  (stat_in),
        .ctrl_out (ctrl_out)
    );

    // R10 monitor: the pull-down enable must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl_m) oe_viol++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic qwait;
        repeat (QCLK) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; qwait;
        scl_m = 1'b1; qwait;
        sda_m = 1'b0; qwait;
        scl_m = 1'b0; qwait;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; qwait;
        scl_m = 1'b1; qwait;
        sda_m = 1'b1; qwait;
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; qwait;
        scl_m = 1'b1; qwait;
        s = sda_line; qwait;
        scl_m = 1'b0; qwait;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic host_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~host_ack, s);
    endtask

    // clocks with SDA released: returns 1 if the line was ever low
    task automatic idle_clocks(output logic seen_low);
        logic s;
        seen_low = 1'b0;
        for (int i = 0; i < 9; i++) begin
            clk_bit(1'b1, s);
            if (!s) seen_low = 1'b1;
        end
    endtask

    task automatic t_reset;
        chk("R1 control bytes after reset", ctrl_out, 64'h0);
        chk("R1 SDA released after reset", {63'h0, sda_oe}, 64'h0);
    endtask

    task automatic t_addr_select;
        logic a;
        addr_sel = 1'b0;
        bus_start; send_byte({ADR1, 1'b0}, a);
        chk("R2 sel=0 foreign address nacked", {63'h0, a}, 64'h0);
        send_byte(8'h00, a); send_byte(8'h55, a); bus_stop;
        chk("R2 foreign-address write ignored", ctrl_out, 64'h0);
        bus_start; send_byte({ADR0, 1'b0}, a); bus_stop;
        chk("R2 sel=0 own address acked", {63'h0, a}, 64'h1);
        addr_sel = 1'b1;
        bus_start; send_byte({ADR0, 1'b0}, a); bus_stop;
        chk("R2 sel=1 0x1C nacked", {63'h0, a}, 64'h0);
        bus_start; send_byte({ADR1, 1'b0}, a); bus_stop;
        chk("R2 sel=1 0x1D acked", {63'h0, a}, 64'h1);
        addr_sel = 1'b0;
    endtask

    task automatic t_write;
        logic a;
        int acks = 0;
        bus_start;
        send_byte({ADR0, 1'b0}, a); acks += int'(a);
        send_byte(8'h02, a); acks += int'(a);
        send_byte(8'hA1, a); acks += int'(a);
        send_byte(8'hB2, a); acks += int'(a);
        send_byte(8'hC3, a); acks += int'(a);
        send_byte(8'hD4, a); acks += int'(a);
        bus_stop;
        chk("R3 all write bytes acked", 64'(acks), 64'd6);
        chk("R3 consecutive bytes stored", ctrl_out, 64'h0000_D4C3_B2A1_0000);
    endtask

    task automatic t_random_read;
        logic a, low;
        logic [7:0] b0, b1;
        bus_start;
        send_byte({ADR0, 1'b0}, a);
        send_byte(8'h03, a);
        bus_start;
        send_byte({ADR0, 1'b1}, a);
        recv_byte(b0, 1'b1);
        recv_byte(b1, 1'b0);
        chk("R5 random read first byte", {56'h0, b0}, 64'hB2);
        chk("R5 random read next address", {56'h0, b1}, 64'hC3);
        chk("R6 SDA released after host nack", {63'h0, sda_oe}, 64'h0);
        idle_clocks(low);
        chk("R6 no drive after nack", {63'h0, low}, 64'h0);
        bus_stop;
    endtask

    task automatic t_current_read;
        logic a;
        logic [7:0] b0;
        bus_start;
        send_byte({ADR0, 1'b1}, a);
        recv_byte(b0, 1'b0);
        bus_stop;
        chk("R4 current read acked", {63'h0, a}, 64'h1);
        chk("R4 current read continues pointer", {56'h0, b0}, 64'hD4);
    endtask

    task automatic t_status;
        logic a;
        int acks = 0;
        logic [7:0] b0, b1, b2, b3;
        bus_start;
        send_byte({ADR0, 1'b0}, a); acks += int'(a);
        send_byte(8'h07, a); acks += int'(a);
        send_byte(8'h77, a); acks += int'(a);
        send_byte(8'hEE, a); acks += int'(a);
        send_byte(8'h99, a); acks += int'(a);
        bus_stop;
        chk("R7 status writes still acked", 64'(acks), 64'd5);
        bus_start;
        send_byte({ADR0, 1'b0}, a);
        send_byte(8'h07, a);
        bus_start;
        send_byte({ADR0, 1'b1}, a);
        recv_byte(b0, 1'b1);
        recv_byte(b1, 1'b1);
        recv_byte(b2, 1'b1);
        recv_byte(b3, 1'b0);
        bus_stop;
        chk("R7 last control byte", {56'h0, b0}, 64'h77);
        chk("R7 status byte 0 from input", {56'h0, b1}, 64'hC3);
        chk("R7 status byte 1 from input", {56'h0, b2}, 64'h5A);
        chk("R7 unused address reads zero", {56'h0, b3}, 64'h00);
    endtask

    task automatic t_wrap;
        logic a;
        bus_start;
        send_byte({ADR0, 1'b0}, a);
        send_byte(8'hFF, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        bus_stop;
        chk("R8 pointer wraps into byte 0", ctrl_out, 64'h7700_D4C3_B2A1_0022);
    endtask

    task automatic t_stop_abort;
        logic a, s, low;
        logic [7:0] b0;
        bus_start;
        send_byte({ADR0, 1'b0}, a);
        send_byte(8'h01, a);
        clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
        bus_stop;
        idle_clocks(low);
        chk("R9 no drive after aborted write", {63'h0, low}, 64'h0);
        chk("R9 partial byte not stored", ctrl_out, 64'h7700_D4C3_B2A1_0022);
        bus_stop;
        bus_start;
        send_byte({ADR0, 1'b1}, a);
        recv_byte(b0, 1'b0);
        bus_stop;
        chk("R9 pointer kept after abort", {56'h0, b0}, 64'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_addr_select;
        t_write;
        t_random_read;
        t_current_read;
        t_status;
        t_wrap;
        t_stop_abort;
        chk("R10 drive changes only with SCL low", 64'(oe_viol), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule